// File: doc/BRIEF.md
# SDRAM Bank Precharge Timing Tracker

This block follows the state of every bank of a four-bank single-data-rate SDRAM from the stream of commands a controller issues. The command arrives already decoded: the operation, the bank address and the level of the A10 address bit. From that stream the block keeps each bank's open or closed state and a set of down-counters. The counters cover the minimum open time after an activate, the recovery time after a precharge, and the automatic close that follows a read or write issued with A10 high. The timing values are static inputs counted in clock cycles.

Every cycle the block reports three things for each bank: whether an activate, a read or write, or a precharge may legally be issued to it. In the same cycle it flags a command that breaks one of these rules. A flagged command is dropped and does not change any bank's state. The controller uses the legality vectors to schedule commands and uses the flag as a protocol-error check.

Top module: `sdram_bank_tracker`

## Requirements
- R1: While reset is low, every bank is closed with all counters cleared. In that state `actOk` and `preOk` are all ones, `rwOk` and `bankOpen` are zero, and `cmdIllegal` is zero for a NOP.
- R2: The command codes on `cmdOp` are 0 NOP, 1 activate, 2 read, 3 write and 4 precharge; other codes act as NOP. An activate is legal only to a closed bank whose recovery has finished. A legal activate opens that bank from the next cycle, and the bank then shows `rwOk` high and `actOk` low.
- R3: A single-bank precharge (A10 low) to an open bank activated in cycle a is illegal before cycle a+`cfgRas`. `preOk` for that bank is low until then.
- R4: A legal precharge issued in cycle p closes its bank from cycle p+1. The bank's `actOk` rises in cycle p+`cfgRp`.
- R5: A precharge with A10 high targets all banks. It is legal only when every bank shows `preOk`, and it then closes every open bank.
- R6: A precharge to a bank that is already closed is legal and leaves that bank's recovery timing unchanged.
- R7: A read or write to a closed bank is flagged illegal.
- R8: A read with A10 high in cycle t, with burst code b in 0..3 on `cfgBurst` (length BL = 2^b), starts the bank's internal precharge at the edge that ends cycle t+BL. This is CAS latency minus one cycles ahead of its last data beat at t+CL+BL-1, so the CAS latency drops out of the count. The bank is closed from t+BL+1, and `actOk` rises at t+BL+`cfgRp`.
- R9: A write with A10 high in cycle t starts the internal precharge at the edge that ends cycle t+BL-1+`cfgWr`, which is write recovery after the last data beat. `actOk` rises at t+BL-1+`cfgWr`+`cfgRp`, the data-in-to-activate delay.
- R10: If the internal precharge would start before `cfgRas` cycles have passed since the bank's activate, the start waits until they have.
- R11: While an automatic close is pending on a bank, a read, write or precharge that targets it is flagged illegal, including a precharge to all banks. That bank's `rwOk` and `preOk` stay low.
- R12: A read or write with A10 high is illegal when `cfgBurst` holds a full-page code (4 to 7). A read or write with A10 low is unaffected by the burst code.
- R13: A command flagged illegal changes no bank state and no counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| cmdOp | input | 3 | Decoded command: 0 NOP, 1 activate, 2 read, 3 write, 4 precharge |
| cmdBank | input | 2 | Bank address of the command |
| cmdA10 | input | 1 | A10 level: auto-close on read/write, all banks on precharge |
| cfgRas | input | 6 | Minimum activate-to-precharge time in cycles |
| cfgRp | input | 6 | Precharge-to-activate time in cycles |
| cfgWr | input | 6 | Write recovery after the last write beat in cycles |
| cfgBurst | input | 3 | Burst code: 0..3 give 1, 2, 4, 8 beats; 4..7 mean full page |
| actOk | output | 4 | Per bank: activate is legal this cycle |
| rwOk | output | 4 | Per bank: read or write is legal this cycle |
| preOk | output | 4 | Per bank: single-bank precharge is legal this cycle |
| bankOpen | output | 4 | Per bank: bank is open |
| cmdIllegal | output | 1 | The present command breaks a rule and is ignored |

## Verification
`cmdIllegal` depends combinationally on the present command and the stored bank state. It is due in the same cycle as the command, so the bench drives each command on the falling edge and samples the flag 1 ns later. The four per-bank vectors change only at the rising edge that ends the command's cycle, so each is sampled 1 ns after that edge. The counted windows (tRAS, tRP, the auto-close start and the tDAL recovery) are checked at the exact cycle worked out from R3, R4 and R8 to R10, and again one cycle before the boundary where a wrong count would show.

// File: rtl/sdram_trk_pkg.sv
package sdram_trk_pkg;

  typedef enum logic [2:0] {
    OP_NOP   = 3'd0,
    OP_ACT   = 3'd1,
    OP_READ  = 3'd2,
    OP_WRITE = 3'd3,
    OP_PRE   = 3'd4
  } cmdOp_e;

  // Per-bank strobes from control to the counter datapath
  typedef struct packed {
    logic act;    // open the bank, load the tRAS counter
    logic pre;    // close now, load the tRP counter
    logic apArm;  // schedule an automatic close
  } bankStrobe_t;

endpackage

// File: rtl/sdram_trk_ctrl.sv
module sdram_trk_ctrl
  import sdram_trk_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  parameter int CNT_W     = 6,
  localparam int BANK_W   = $clog2(NUM_BANKS)
) (
  input  logic [2:0]              cmdOp,
  input  logic [BANK_W-1:0]       cmdBank,
  input  logic                    cmdA10,
  input  logic [CNT_W-1:0]        cfgWr,
  input  logic [2:0]              cfgBurst,
  input  logic [NUM_BANKS-1:0]    isOpen,
  input  logic [NUM_BANKS-1:0]    apBusy,
  input  logic [NUM_BANKS-1:0]    rasDone,
  input  logic [NUM_BANKS-1:0]    rpDone,
  output bankStrobe_t [NUM_BANKS-1:0] strobes,
  output logic [CNT_W-1:0]        apDelayM1,
  output logic [NUM_BANKS-1:0]    actOk,
  output logic [NUM_BANKS-1:0]    rwOk,
  output logic [NUM_BANKS-1:0]    preOk,
  output logic                    cmdIllegal
);

  localparam logic [CNT_W:0] CNT_MAX = {1'b0, {CNT_W{1'b1}}};

  cmdOp_e            op;
  logic              fullPage;
  logic [CNT_W-1:0]  burstLen;
  logic [CNT_W:0]    wrSum;
  logic [CNT_W:0]    wrSumM1;
  logic [CNT_W-1:0]  wrDelayM1;
  logic [NUM_BANKS-1:0] bankSel;
  logic              isRw;
  logic              legal;

  assign op       = cmdOp_e'(cmdOp);
  assign fullPage = cfgBurst[2];
  assign burstLen = CNT_W'(1) << cfgBurst[1:0];
  assign isRw     = (op == OP_READ) || (op == OP_WRITE);

  // Write close: last beat at BL-1, then write recovery
  assign wrSum     = {1'b0, burstLen} - (CNT_W+1)'(1) + {1'b0, cfgWr};
  assign wrSumM1   = (wrSum == '0) ? '0 : wrSum - (CNT_W+1)'(1);
  assign wrDelayM1 = (wrSumM1 > CNT_MAX) ? CNT_MAX[CNT_W-1:0] : wrSumM1[CNT_W-1:0];
  // Read close: CL-1 ahead of the last beat at CL+BL-1, i.e. BL after the command
  assign apDelayM1 = (op == OP_WRITE) ? wrDelayM1 : burstLen - CNT_W'(1);

  assign actOk = ~isOpen & rpDone;
  assign rwOk  = isOpen & ~apBusy;
  assign preOk = ~apBusy & (~isOpen | rasDone);

  always_comb begin
    bankSel = '0;
    bankSel[cmdBank] = 1'b1;
  end

  always_comb begin
    case (op)
      OP_ACT:             cmdIllegal = !actOk[cmdBank];
      OP_READ, OP_WRITE:  cmdIllegal = !rwOk[cmdBank] || (cmdA10 && fullPage);
      OP_PRE:             cmdIllegal = cmdA10 ? !(&preOk) : !preOk[cmdBank];
      default:            cmdIllegal = 1'b0;
    endcase
  end

  assign legal = !cmdIllegal;

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_strobe
    assign strobes[b].act   = (op == OP_ACT) && legal && bankSel[b];
    assign strobes[b].pre   = (op == OP_PRE) && legal && (cmdA10 || bankSel[b]) && isOpen[b];
    assign strobes[b].apArm = isRw && cmdA10 && legal && bankSel[b];
  end

endmodule

// File: rtl/sdram_trk_bankdp.sv
module sdram_trk_bankdp
  import sdram_trk_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  parameter int CNT_W     = 6
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  bankStrobe_t [NUM_BANKS-1:0] strobes,
  input  logic [CNT_W-1:0]            apDelayM1,
  input  logic [CNT_W-1:0]            cfgRas,
  input  logic [CNT_W-1:0]            cfgRp,
  output logic [NUM_BANKS-1:0]        isOpen,
  output logic [NUM_BANKS-1:0]        apBusy,
  output logic [NUM_BANKS-1:0]        rasDone,
  output logic [NUM_BANKS-1:0]        rpDone
);

  logic [CNT_W-1:0] rasLoad;
  logic [CNT_W-1:0] rpLoad;

  assign rasLoad = (cfgRas == '0) ? '0 : cfgRas - CNT_W'(1);
  assign rpLoad  = (cfgRp  == '0) ? '0 : cfgRp  - CNT_W'(1);

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic             openQ;
    logic             apPendQ;
    logic [CNT_W-1:0] rasCnt;
    logic [CNT_W-1:0] rpCnt;
    logic [CNT_W-1:0] apCnt;
    logic             apFire;

    // Auto-close starts once its delay has run out and tRAS is met
    assign apFire = apPendQ && (apCnt == '0) && (rasCnt == '0);

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        openQ   <= 1'b0;
        apPendQ <= 1'b0;
        rasCnt  <= '0;
        rpCnt   <= '0;
        apCnt   <= '0;
      end else begin
        if (strobes[b].act)       rasCnt <= rasLoad;
        else if (rasCnt != '0)    rasCnt <= rasCnt - CNT_W'(1);

        if (strobes[b].pre || apFire) begin
          openQ   <= 1'b0;
          apPendQ <= 1'b0;
          rpCnt   <= rpLoad;
        end else begin
          if (strobes[b].act)     openQ <= 1'b1;
          if (rpCnt != '0)        rpCnt <= rpCnt - CNT_W'(1);
          if (strobes[b].apArm)   apPendQ <= 1'b1;
        end

        if (strobes[b].apArm)     apCnt <= apDelayM1;
        else if (apCnt != '0)     apCnt <= apCnt - CNT_W'(1);
      end
    end

    assign isOpen[b]  = openQ;
    assign apBusy[b]  = apPendQ;
    assign rasDone[b] = (rasCnt == '0);
    assign rpDone[b]  = (rpCnt == '0);
  end

endmodule

// File: rtl/sdram_bank_tracker.sv
module sdram_bank_tracker
  import sdram_trk_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  parameter int CNT_W     = 6,
  localparam int BANK_W   = $clog2(NUM_BANKS)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [2:0]           cmdOp,
  input  logic [BANK_W-1:0]    cmdBank,
  input  logic                 cmdA10,
  input  logic [CNT_W-1:0]     cfgRas,
  input  logic [CNT_W-1:0]     cfgRp,
  input  logic [CNT_W-1:0]     cfgWr,
  input  logic [2:0]           cfgBurst,
  output logic [NUM_BANKS-1:0] actOk,
  output logic [NUM_BANKS-1:0] rwOk,
  output logic [NUM_BANKS-1:0] preOk,
  output logic [NUM_BANKS-1:0] bankOpen,
  output logic                 cmdIllegal
);

  bankStrobe_t [NUM_BANKS-1:0] strobes;
  logic [CNT_W-1:0]     apDelayM1;
  logic [NUM_BANKS-1:0] apBusy;
  logic [NUM_BANKS-1:0] rasDone;
  logic [NUM_BANKS-1:0] rpDone;

  sdram_trk_ctrl #(.NUM_BANKS(NUM_BANKS), .CNT_W(CNT_W)) ctrl_i (
    .cmdOp(cmdOp), .cmdBank(cmdBank), .cmdA10(cmdA10),
    .cfgWr(cfgWr), .cfgBurst(cfgBurst),
    .isOpen(bankOpen), .apBusy(apBusy), .rasDone(rasDone), .rpDone(rpDone),
    .strobes(strobes), .apDelayM1(apDelayM1),
    .actOk(actOk), .rwOk(rwOk), .preOk(preOk), .cmdIllegal(cmdIllegal)
  );

  sdram_trk_bankdp #(.NUM_BANKS(NUM_BANKS), .CNT_W(CNT_W)) dp_i (
    .clk(clk), .rstN(rstN), .strobes(strobes), .apDelayM1(apDelayM1),
    .cfgRas(cfgRas), .cfgRp(cfgRp),
    .isOpen(bankOpen), .apBusy(apBusy), .rasDone(rasDone), .rpDone(rpDone)
  );

endmodule

// File: rtl/sdram_trk_chk.sv
module sdram_trk_chk #(
  parameter int NUM_BANKS = 4,
  localparam int BANK_W   = $clog2(NUM_BANKS)
) (
  input logic                 clk,
  input logic                 rstN,
  input logic [2:0]           cmdOp,
  input logic [BANK_W-1:0]    cmdBank,
  input logic                 cmdA10,
  input logic                 fullPage,
  input logic [NUM_BANKS-1:0] actOk,
  input logic [NUM_BANKS-1:0] rwOk,
  input logic [NUM_BANKS-1:0] bankOpen,
  input logic                 cmdIllegal
);

  logic isRw;
  assign isRw = (cmdOp == 3'd2) || (cmdOp == 3'd3);

  AST_ACT_OPENS: assert property (@(posedge clk) disable iff (!rstN)
    (cmdOp == 3'd1 && !cmdIllegal) |=> bankOpen[$past(cmdBank)]); // R2

  AST_ACT_CLEARS_ACTOK: assert property (@(posedge clk) disable iff (!rstN)
    (cmdOp == 3'd1 && !cmdIllegal) |=> !actOk[$past(cmdBank)]); // R2

  AST_PRE_CLOSES: assert property (@(posedge clk) disable iff (!rstN)
    (cmdOp == 3'd4 && !cmdA10 && !cmdIllegal) |=> !bankOpen[$past(cmdBank)]); // R4

  AST_PREALL_CLOSES: assert property (@(posedge clk) disable iff (!rstN)
    (cmdOp == 3'd4 && cmdA10 && !cmdIllegal) |=> (bankOpen == '0)); // R5

  AST_RW_CLOSED_BAD: assert property (@(posedge clk) disable iff (!rstN)
    (isRw && !bankOpen[cmdBank]) |-> cmdIllegal); // R7

  AST_RWOK_NEEDS_OPEN: assert property (@(posedge clk) disable iff (!rstN)
    ((rwOk & ~bankOpen) == '0)); // R7

  AST_FULLPAGE_AP_BAD: assert property (@(posedge clk) disable iff (!rstN)
    (isRw && cmdA10 && fullPage) |-> cmdIllegal); // R12

  AST_BAD_ACT_NO_OPEN: assert property (@(posedge clk) disable iff (!rstN)
    (cmdOp == 3'd1 && cmdIllegal && !bankOpen[cmdBank]) |=> !bankOpen[$past(cmdBank)]); // R13

endmodule

bind sdram_bank_tracker sdram_trk_chk #(.NUM_BANKS(NUM_BANKS)) chk_i (
  .clk(clk), .rstN(rstN), .cmdOp(cmdOp), .cmdBank(cmdBank), .cmdA10(cmdA10),
  .fullPage(cfgBurst[2]), .actOk(actOk), .rwOk(rwOk), .bankOpen(bankOpen),
  .cmdIllegal(cmdIllegal)
);

// File: tb/sdram_bank_tracker_tb_top.sv
`timescale 1ns/1ps
module sdram_bank_tracker_tb_top;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [2:0] cmdOp = 3'd0;
  logic [1:0] cmdBank = 2'd0;
  logic       cmdA10 = 1'b0;
  logic [5:0] cfgRas = 6'd3;
  logic [5:0] cfgRp = 6'd2;
  logic [5:0] cfgWr = 6'd2;
  logic [2:0] cfgBurst = 3'd2;
  logic [3:0] actOk, rwOk, preOk, bankOpen;
  logic       cmdIllegal;

  int total = 0;
  int bad = 0;

  always #4 clk = ~clk;

  sdram_bank_tracker dut_i (
    .clk(clk), .rstN(rstN), .cmdOp(cmdOp), .cmdBank(cmdBank), .cmdA10(cmdA10),
    .cfgRas(cfgRas), .cfgRp(cfgRp), .cfgWr(cfgWr), .cfgBurst(cfgBurst),
    .actOk(actOk), .rwOk(rwOk), .preOk(preOk), .bankOpen(bankOpen),
    .cmdIllegal(cmdIllegal)
  );

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // {op[22:20], bank[19:18], a10[17], illegal[16], open[15:12], act[11:8], rw[7:4], pre[3:0]}
  // cfgRas=3 cfgRp=2 cfgWr=2 burst code 2 (BL=4)
  localparam logic [22:0] VEC [0:28] = '{
    {3'd1, 2'd0, 1'b0, 1'b0, 4'h1, 4'hE, 4'h1, 4'hE},  // 0  ACT b0
    {3'd0, 2'd0, 1'b0, 1'b0, 4'h1, 4'hE, 4'h1, 4'hE},  // 1
    {3'd4, 2'd0, 1'b0, 1'b1, 4'h1, 4'hE, 4'h1, 4'hF},  // 2  PRE early
    {3'd2, 2'd0, 1'b1, 1'b0, 4'h1, 4'hE, 4'h0, 4'hE},  // 3  RD auto-close
    {3'd3, 2'd0, 1'b0, 1'b1, 4'h1, 4'hE, 4'h0, 4'hE},  // 4  WR while pending
    {3'd1, 2'd1, 1'b0, 1'b0, 4'h3, 4'hC, 4'h2, 4'hC},  // 5  ACT b1
    {3'd4, 2'd0, 1'b0, 1'b1, 4'h3, 4'hC, 4'h2, 4'hC},  // 6  PRE while pending
    {3'd0, 2'd0, 1'b0, 1'b0, 4'h2, 4'hC, 4'h2, 4'hF},  // 7  b0 closes
    {3'd1, 2'd0, 1'b0, 1'b1, 4'h2, 4'hD, 4'h2, 4'hF},  // 8  ACT inside tRP
    {3'd3, 2'd1, 1'b1, 1'b0, 4'h2, 4'hD, 4'h0, 4'hD},  // 9  WR auto-close
    {3'd4, 2'd0, 1'b1, 1'b1, 4'h2, 4'hD, 4'h0, 4'hD},  // 10 PRE all while pending
    {3'd2, 2'd1, 1'b1, 1'b1, 4'h2, 4'hD, 4'h0, 4'hD},  // 11 RD while pending
    {3'd0, 2'd0, 1'b0, 1'b0, 4'h2, 4'hD, 4'h0, 4'hD},  // 12
    {3'd0, 2'd0, 1'b0, 1'b0, 4'h2, 4'hD, 4'h0, 4'hD},  // 13
    {3'd0, 2'd0, 1'b0, 1'b0, 4'h0, 4'hD, 4'h0, 4'hF},  // 14 b1 closes
    {3'd0, 2'd0, 1'b0, 1'b0, 4'h0, 4'hF, 4'h0, 4'hF},  // 15 tDAL met
    {3'd1, 2'd2, 1'b0, 1'b0, 4'h4, 4'hB, 4'h4, 4'hB},  // 16 ACT b2
    {3'd1, 2'd3, 1'b0, 1'b0, 4'hC, 4'h3, 4'hC, 4'h3},  // 17 ACT b3
    {3'd4, 2'd0, 1'b1, 1'b1, 4'hC, 4'h3, 4'hC, 4'h7},  // 18 PRE all early
    {3'd0, 2'd0, 1'b0, 1'b0, 4'hC, 4'h3, 4'hC, 4'hF},  // 19
    {3'd4, 2'd0, 1'b1, 1'b0, 4'h0, 4'h3, 4'h0, 4'hF},  // 20 PRE all
    {3'd0, 2'd0, 1'b0, 1'b0, 4'h0, 4'hF, 4'h0, 4'hF},  // 21
    {3'd2, 2'd0, 1'b0, 1'b1, 4'h0, 4'hF, 4'h0, 4'hF},  // 22 RD closed bank
    {3'd1, 2'd0, 1'b0, 1'b0, 4'h1, 4'hE, 4'h1, 4'hE},  // 23 ACT b0
    {3'd2, 2'd0, 1'b0, 1'b0, 4'h1, 4'hE, 4'h1, 4'hE},  // 24 RD
    {3'd3, 2'd0, 1'b0, 1'b0, 4'h1, 4'hE, 4'h1, 4'hF},  // 25 WR, tRAS met
    {3'd4, 2'd0, 1'b0, 1'b0, 4'h0, 4'hE, 4'h0, 4'hF},  // 26 PRE b0
    {3'd0, 2'd0, 1'b0, 1'b0, 4'h0, 4'hF, 4'h0, 4'hF},  // 27 tRP met
    {3'd4, 2'd0, 1'b0, 1'b0, 4'h0, 4'hF, 4'h0, 4'hF}   // 28 PRE idle bank
  };

  function automatic string reqOf(input int i);
    case (i)
      0, 5, 16, 17, 23:   return "R2";
      1, 19, 24, 25:      return "R3";
      2, 8:               return "R13";
      3, 7:               return "R8";
      4, 6, 10, 11:       return "R11";
      9, 12, 13, 14, 15:  return "R9";
      18, 20:             return "R5";
      21, 26, 27:         return "R4";
      22:                 return "R7";
      default:            return "R6";
    endcase
  endfunction

  task automatic summary();
    $display("test done: total=%0d bad=%0d", total, bad);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog: actual=running expected=finished");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1 reset state
    chk("R1", "bankOpen", 32'(bankOpen), 32'h0);
    chk("R1", "actOk", 32'(actOk), 32'hF);
    chk("R1", "rwOk", 32'(rwOk), 32'h0);
    chk("R1", "preOk", 32'(preOk), 32'hF);
    chk("R1", "cmdIllegal", 32'(cmdIllegal), 32'h0);
    rstN = 1'b1;

    for (int i = 0; i < 29; i++) begin
      @(negedge clk);
      cmdOp   = VEC[i][22:20];
      cmdBank = VEC[i][19:18];
      cmdA10  = VEC[i][17];
      #1;
      chk(reqOf(i), $sformatf("step %0d illegal", i), 32'(cmdIllegal), 32'(VEC[i][16]));
      @(posedge clk);
      #1;
      chk(reqOf(i), $sformatf("step %0d bankOpen", i), 32'(bankOpen), 32'(VEC[i][15:12]));
      chk(reqOf(i), $sformatf("step %0d actOk", i), 32'(actOk), 32'(VEC[i][11:8]));
      chk(reqOf(i), $sformatf("step %0d rwOk", i), 32'(rwOk), 32'(VEC[i][7:4]));
      chk(reqOf(i), $sformatf("step %0d preOk", i), 32'(preOk), 32'(VEC[i][3:0]));
    end

    // R10: auto-close waits for tRAS (cfgRas=6, BL=1)
    @(negedge clk);
    cfgRas = 6'd6; cfgBurst = 3'd0;
    cmdOp = 3'd1; cmdBank = 2'd0; cmdA10 = 1'b0;      // cycle A
    @(negedge clk);
    cmdOp = 3'd2; cmdA10 = 1'b1;                       // cycle A+1
    #1 chk("R10", "read auto-close legal", 32'(cmdIllegal), 32'h0);
    @(negedge clk);
    cmdOp = 3'd0; cmdA10 = 1'b0;                       // cycle A+2
    repeat (3) @(posedge clk);
    #1;                                                // cycle A+5
    chk("R10", "open before tRAS", 32'(bankOpen[0]), 32'h1);
    chk("R11", "rwOk while pending", 32'(rwOk[0]), 32'h0);
    repeat (2) @(posedge clk);
    #1;                                                // cycle A+7
    chk("R10", "closed after tRAS", 32'(bankOpen[0]), 32'h0);

    // R12: full page forbids auto-close
    @(negedge clk);
    cfgBurst = 3'd7;
    cmdOp = 3'd1; cmdBank = 2'd1;
    #1 chk("R2", "ACT b1", 32'(cmdIllegal), 32'h0);
    @(negedge clk);
    cmdOp = 3'd2; cmdA10 = 1'b1;
    #1 chk("R12", "full-page auto-close", 32'(cmdIllegal), 32'h1);
    @(posedge clk);
    #1 chk("R13", "ignored auto-close keeps rwOk", 32'(rwOk[1]), 32'h1);
    @(negedge clk);
    cmdA10 = 1'b0;
    #1 chk("R12", "full-page plain read", 32'(cmdIllegal), 32'h0);
    @(negedge clk);
    cmdOp = 3'd0;
    @(negedge clk);

    summary();
    $finish;
  end

endmodule